// File: doc/BRIEF.md
# In-place radix-2 FFT address sequencer

This block steps an in-place radix-2 transform over `N_PTS` points, where `N_PTS` is a power of two. It drives no data and does no arithmetic. It only produces the two memory addresses that each butterfly reads and later writes back. After a start request the block runs `log2(N_PTS)` stages of `N_PTS/2` butterflies each. For every butterfly it issues two beats on a ready/valid output: a fetch beat, then a store beat.

The distance between the two addresses of a pair is half the array in the first stage. It halves again in each later stage. In every stage except the last, the store beat repeats the fetch addresses. In the last stage the store addresses are the bit-reversed forms of the fetch addresses, so the transformed data ends up in natural order. A one-cycle done pulse marks the end of the sequence. The external datapath uses `stage_o` and `bfly_o` to choose twiddle factors.

Top module: `fft_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` and `done_o` are 0 until a start is accepted.
- R2: A sequence consists of `log2(N_PTS)` stages numbered 0 upward on `stage_o`. Each stage has `N_PTS/2` butterflies numbered 0 upward on `bfly_o`. Each butterfly is issued as a fetch beat (`store_o`=0) followed by a store beat (`store_o`=1), and `valid_o` stays high until the last store beat is accepted.
- R3: In stage s the pair span is `N_PTS >> (s+1)`. On a fetch beat, `addr_b_o` equals `addr_a_o` plus the span, and the span bit of `addr_a_o` is 0.
- R4: Within a stage, `addr_a_o` takes the indices whose span bit is clear, in ascending order with the butterfly index. Taken together, the fetch pairs of one stage cover every address exactly once.
- R5: In every stage but the last, the store beat carries the same two addresses as the fetch beat that precedes it.
- R6: In the last stage, the store beat carries the `log2(N_PTS)`-bit bit reversal of each fetch address: bit i moves to bit `log2(N_PTS)-1-i`.
- R7: While `valid_o` is 1 and `ready_i` is 0, all outputs hold their values into the next cycle.
- R8: `done_o` is 1 for exactly one cycle, the cycle after the last store beat is accepted, and `valid_o` is 0 in that cycle.
- R9: A start request made while a sequence is in progress has no effect: the sequence neither restarts nor gains extra beats.
- R10: When idle, a start request is accepted at the clock edge, and in the next cycle `valid_o` is 1 with stage 0, butterfly 0, fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new sequence (used only when idle) |
| ready_i | input | 1 | Consumer accepts the current beat |
| valid_o | output | 1 | A beat is presented |
| store_o | output | 1 | 0 = fetch beat, 1 = store beat |
| addr_a_o | output | log2(N_PTS) | Lower address of the pair |
| addr_b_o | output | log2(N_PTS) | Upper address of the pair |
| stage_o | output | clog2(log2(N_PTS)) | Current stage index |
| bfly_o | output | log2(N_PTS)-1 | Butterfly index within the stage |
| done_o | output | 1 | One-cycle pulse after the final store beat |

## Verification
The full sequence of a 16-point configuration is swept three times. The first sweep keeps ready high, which shows that beats move one per cycle with no bubble. The second applies a periodic back-pressure pattern, which separates a correct hold from an early advance or a dropped beat. The third repeats that back-pressure and also raises start in the middle of the run, which would expose a restart or an extra beat. For every beat the bench rebuilds the expected pair by searching for the n-th index with the span bit clear, and performs bit reversal by looping over the bits. Coverage of each stage is checked with a visit mask, and the done pulse is timed relative to the last handshake.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  typedef enum logic {
    BEAT_FETCH = 1'b0,
    BEAT_STORE = 1'b1
  } beat_e;
endpackage

// File: rtl/fft_seq_bitrev.sv
module fft_seq_bitrev #(
  parameter int W = 4
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign q_o[i] = d_i[W-1-i];
  end
endmodule

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
  import fft_seq_pkg::*;
#(
  parameter int LOG_N = 4,
  localparam int BW = LOG_N - 1,
  localparam int SW = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          busy_o,
  output logic [SW-1:0] stage_o,
  output logic [BW-1:0] bfly_o,
  output beat_e         kind_o,
  output logic          last_stage_o,
  output logic          done_o
);
  logic          busy_q, done_q;
  logic [SW-1:0] stage_q;
  logic [BW-1:0] bfly_q;
  beat_e         kind_q;
  logic          accept, last_bfly, last_stage, last_beat;

  assign accept     = busy_q & ready_i;
  assign last_bfly  = &bfly_q;
  assign last_stage = (stage_q == SW'(LOG_N - 1));
  assign last_beat  = accept & (kind_q == BEAT_STORE) & last_bfly & last_stage;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
      bfly_q  <= '0;
      kind_q  <= BEAT_FETCH;
    end else begin
      done_q <= last_beat;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          stage_q <= '0;
          bfly_q  <= '0;
          kind_q  <= BEAT_FETCH;
        end
      end else if (accept) begin
        if (kind_q == BEAT_FETCH) begin
          kind_q <= BEAT_STORE;
        end else begin
          kind_q <= BEAT_FETCH;
          if (last_bfly) begin
            bfly_q <= '0;
            if (last_stage) busy_q <= 1'b0;
            else            stage_q <= stage_q + SW'(1);
          end else begin
            bfly_q <= bfly_q + BW'(1);
          end
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign stage_o      = stage_q;
  assign bfly_o       = bfly_q;
  assign kind_o       = kind_q;
  assign last_stage_o = last_stage;
  assign done_o       = done_q;
endmodule

// File: rtl/fft_seq_addr_gen.sv
module fft_seq_addr_gen
  import fft_seq_pkg::*;
#(
  parameter int LOG_N = 4,
  localparam int AW = LOG_N,
  localparam int BW = LOG_N - 1,
  localparam int SW = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input  logic [SW-1:0] stage_i,
  input  logic [BW-1:0] bfly_i,
  input  beat_e         kind_i,
  input  logic          last_stage_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o
);
  logic [AW-1:0] span, lo_mask, hi_mask, k_a, k_b, rev_a, rev_b;

  // one-hot span, halving per stage
  assign span    = AW'(1) << (LOG_N - 1 - int'(stage_i));
  assign lo_mask = span - AW'(1);
  assign hi_mask = ~((span << 1) - AW'(1));
  // butterfly index with a zero inserted at the span bit
  assign k_a     = ({bfly_i, 1'b0} & hi_mask) | ({1'b0, bfly_i} & lo_mask);
  assign k_b     = k_a | span;

  fft_seq_bitrev #(.W(AW)) u_rev_a (.d_i(k_a), .q_o(rev_a));
  fft_seq_bitrev #(.W(AW)) u_rev_b (.d_i(k_b), .q_o(rev_b));

  always_comb begin
    if (kind_i == BEAT_STORE && last_stage_i) begin
      addr_a_o = rev_a;
      addr_b_o = rev_b;
    end else begin
      addr_a_o = k_a;
      addr_b_o = k_b;
    end
  end
endmodule

// File: rtl/fft_addr_seq.sv
module fft_addr_seq
  import fft_seq_pkg::*;
#(
  parameter int N_PTS = 16,
  localparam int LOG_N = $clog2(N_PTS),
  localparam int AW = LOG_N,
  localparam int BW = LOG_N - 1,
  localparam int SW = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          store_o,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [SW-1:0] stage_o,
  output logic [BW-1:0] bfly_o,
  output logic          done_o
);
  logic          busy, last_stage;
  logic [SW-1:0] stage;
  logic [BW-1:0] bfly;
  beat_e         kind;

  fft_seq_ctrl #(.LOG_N(LOG_N)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ready_i     (ready_i),
    .busy_o      (busy),
    .stage_o     (stage),
    .bfly_o      (bfly),
    .kind_o      (kind),
    .last_stage_o(last_stage),
    .done_o      (done_o)
  );

  fft_seq_addr_gen #(.LOG_N(LOG_N)) u_addr (
    .stage_i     (stage),
    .bfly_i      (bfly),
    .kind_i      (kind),
    .last_stage_i(last_stage),
    .addr_a_o    (addr_a_o),
    .addr_b_o    (addr_b_o)
  );

  assign valid_o = busy;
  assign store_o = (kind == BEAT_STORE);
  assign stage_o = stage;
  assign bfly_o  = bfly;
endmodule

// File: rtl/fft_addr_seq_chk.sv
module fft_addr_seq_chk #(
  parameter int N_PTS = 16,
  localparam int LOG_N = $clog2(N_PTS),
  localparam int AW = LOG_N,
  localparam int BW = LOG_N - 1,
  localparam int SW = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ready_i,
  input logic          valid_o,
  input logic          store_o,
  input logic [AW-1:0] addr_a_o,
  input logic [AW-1:0] addr_b_o,
  input logic [SW-1:0] stage_o,
  input logic [BW-1:0] bfly_o,
  input logic          done_o
);
  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [AW:0] span_w;
  logic        fin;
  assign span_w = (AW+1)'(N_PTS) >> (int'(stage_o) + 1);
  assign fin    = (stage_o == SW'(LOG_N - 1));

  a_r1_idle_reset: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && !done_o);

  a_r3_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !store_o |-> (addr_b_o - addr_a_o) == AW'(span_w) && (addr_a_o & AW'(span_w)) == '0);

  a_r5_store_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !store_o && !fin |=>
      store_o && addr_a_o == $past(addr_a_o) && addr_b_o == $past(addr_b_o));

  a_r6_store_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !store_o && fin |=>
      store_o && addr_a_o == rev($past(addr_a_o)) && addr_b_o == rev($past(addr_b_o)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_a_o) && $stable(addr_b_o)
      && $stable(store_o) && $stable(stage_o) && $stable(bfly_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o ##1 !done_o);

  a_r9_start_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));

  a_r10_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> stage_o == '0 && bfly_o == '0 && !store_o);
endmodule

bind fft_addr_seq fft_addr_seq_chk #(.N_PTS(N_PTS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_i (ready_i),
  .valid_o (valid_o),
  .store_o (store_o),
  .addr_a_o(addr_a_o),
  .addr_b_o(addr_b_o),
  .stage_o (stage_o),
  .bfly_o  (bfly_o),
  .done_o  (done_o)
);

// File: tb/fft_addr_seq_tb_top.sv
module fft_addr_seq_tb_top;
  localparam int N    = 16;
  localparam int LG   = 4;
  localparam int HALF = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ready_i = 1'b0;
  logic valid_o, store_o, done_o;
  logic [LG-1:0] addr_a_o, addr_b_o;
  logic [1:0] stage_o;
  logic [LG-2:0] bfly_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fft_addr_seq #(.N_PTS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .ready_i(ready_i),
    .valid_o(valid_o), .store_o(store_o), .addr_a_o(addr_a_o), .addr_b_o(addr_b_o),
    .stage_o(stage_o), .bfly_o(bfly_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // n-th index (ascending) whose span bit is clear
  function automatic int nth_clear(input int n, input int span);
    int cnt = 0;
    for (int i = 0; i < N; i++) begin
      if ((i & span) == 0) begin
        if (cnt == n) return i;
        cnt++;
      end
    end
    return -1;
  endfunction

  function automatic int bitrev(input int v);
    int r = 0;
    for (int i = 0; i < LG; i++) if (v & (1 << i)) r |= 1 << (LG - 1 - i);
    return r;
  endfunction

  task automatic run(input int mode);
    int ex_s = 0, ex_b = 0, ex_st = 0, cyc = 0, beats = 0;
    int mask = 0;
    bit held = 0, r, stop = 0;
    int h_a = 0, h_b = 0, h_s = 0, h_bf = 0, h_st = 0;
    int span, ea, eb;
    @(negedge clk);
    start_i = 1'b1;
    ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // R10: first beat the cycle after start
    chk(valid_o === 1'b1, "R10 valid after start", int'(valid_o), 1);
    chk(stage_o == 0 && bfly_o == 0 && store_o == 0, "R10 first beat",
        int'(stage_o) * 100 + int'(bfly_o) * 10 + int'(store_o), 0);
    while (!stop) begin
      if (held) begin
        chk(int'(addr_a_o) == h_a && int'(addr_b_o) == h_b && int'(stage_o) == h_s
            && int'(bfly_o) == h_bf && int'(store_o) == h_st, "R7 hold",
            int'(addr_a_o), h_a);
      end
      if (valid_o !== 1'b1) begin
        chk(0, "R2 valid dropped mid-run", int'(valid_o), 1);
        stop = 1;
      end else begin
        chk(done_o == 1'b0, "R8 no done mid-run", int'(done_o), 0);
        span = N >> (ex_s + 1);
        ea = nth_clear(ex_b, span);
        eb = ea + span;
        if (ex_st == 1 && ex_s == LG - 1) begin
          ea = bitrev(ea);
          eb = bitrev(eb);
        end
        chk(int'(stage_o) == ex_s, "R2 stage", int'(stage_o), ex_s);
        chk(int'(bfly_o) == ex_b, "R2 butterfly", int'(bfly_o), ex_b);
        chk(int'(store_o) == ex_st, "R2 beat kind", int'(store_o), ex_st);
        if (ex_st == 0) begin
          chk(int'(addr_a_o) == ea, "R3 R4 fetch addr_a", int'(addr_a_o), ea);
          chk(int'(addr_b_o) == eb, "R3 fetch addr_b", int'(addr_b_o), eb);
        end else if (ex_s == LG - 1) begin
          chk(int'(addr_a_o) == ea, "R6 reversed store addr_a", int'(addr_a_o), ea);
          chk(int'(addr_b_o) == eb, "R6 reversed store addr_b", int'(addr_b_o), eb);
        end else begin
          chk(int'(addr_a_o) == ea, "R5 store addr_a", int'(addr_a_o), ea);
          chk(int'(addr_b_o) == eb, "R5 store addr_b", int'(addr_b_o), eb);
        end
        r = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        ready_i = r;
        start_i = (mode == 2 && (beats == 20 || beats == 21)) ? 1'b1 : 1'b0; // R9
        held = !r;
        h_a = int'(addr_a_o); h_b = int'(addr_b_o); h_s = int'(stage_o);
        h_bf = int'(bfly_o); h_st = int'(store_o);
        if (r) begin
          beats++;
          if (ex_st == 0) begin
            mask |= (1 << ea) | (1 << eb);
            ex_st = 1;
          end else begin
            ex_st = 0;
            if (ex_b == HALF - 1) begin
              chk(mask == (1 << N) - 1, "R4 stage coverage", mask, (1 << N) - 1);
              mask = 0;
              ex_b = 0;
              if (ex_s == LG - 1) stop = 1;
              else ex_s++;
            end else begin
              ex_b++;
            end
          end
        end
      end
      cyc++;
      @(negedge clk);
    end
    ready_i = 1'b0;
    start_i = 1'b0;
    chk(beats == LG * N, "R2 R9 beat count", beats, LG * N);
    chk(done_o === 1'b1, "R8 done pulse", int'(done_o), 1);
    chk(valid_o === 1'b0, "R8 valid low at done", int'(valid_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 done one cycle", int'(done_o), 0);
    chk(valid_o === 1'b0, "R9 no restart", int'(valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && done_o === 1'b0, "R1 in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && done_o === 1'b0, "R1 after reset", int'(valid_o), 0);
    run(0);
    run(1);
    run(2);
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0, "R9 idle at end", int'(valid_o), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule